// File: doc/BRIEF.md
# Reset Cause Control Register

This block is a single 32-bit control and status register that tells software why the system last went through reset. Software can also use it to ask for a new system reset. It sits on a simple register port. The port has an address, a write strobe, write data and a combinational read-data return. Inside the decoded range, only one 32-bit word is live.

The register holds five flag bits in its top end:

- bit 31 is the power-on cause;
- bits 28 and 27 are the two button causes;
- bit 30 requests a soft power-on reset;
- bit 29 requests a soft externally initiated reset.

The three cause bits are cleared by writing ones to them. The two request bits are set by writing ones and cannot be cleared by a write.

Writing a one to either request bit makes the block emit a one-cycle `sys_reset_req` pulse. The reset network outside the block answers later with a `sys_reset_done` strobe. A soft power-on request also arms the register, so the next completed reset reloads it with only the power-on cause set. Any other completed reset leaves the contents as they are. The power-up reset (`rst_n`) counts as the first reset and loads the same power-on value.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After power-up reset the register reads 0x80000000 (only bit 31 set) and `sys_reset_req` is low.
- R2: Only the word at BASE_ADDR+4 (address bit 2 set, bits 1:0 ignored) is active. BASE_ADDR+0..3 and every other address read zero and ignore writes.
- R3: Bits 31, 28 and 27 clear when written with one and keep their value when written with zero.
- R4: Bits 30 and 29 become one when written with one; writing zero to them leaves them unchanged.
- R5: Bits 26:0 always read zero, whatever is written.
- R6: An accepted write with bit 30 set drives `sys_reset_req` high for exactly the one cycle after the write edge, and the following `sys_reset_done` loads the register with 0x80000000.
- R7: An accepted write with bit 29 set and bit 30 clear pulses `sys_reset_req` the same way, but the following `sys_reset_done` leaves the register unchanged.
- R8: A `sys_reset_done` with no armed soft power-on request leaves the register unchanged; an arm is consumed by the first reset after it.
- R9: When `sys_reset_done` and a write arrive in the same cycle, the reset wins: the write has no effect on the register, the arm or the request output.
- R10: Reads have no side effects on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wr_en | input | 1 | Write strobe for the current cycle |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_data | output | DATA_W | Read data for `reg_addr`, combinational |
| sys_reset_done | input | 1 | One-cycle strobe marking a completed system reset |
| sys_reset_req | output | 1 | One-cycle system reset request pulse |

## Verification
A wrong value in the stored flags appears on the next read of the active word. Because the read path is combinational, the error shows in the same cycle it is sampled.

A lost or spurious arm cannot be seen until the next `sys_reset_done`. One cycle after that strobe, the register either holds 0x80000000 or keeps its old value, and that value exposes the arm. For this reason the stimulus interleaves reset strobes with request writes.

A fault in the request path shows as a missing, extra or stretched `sys_reset_req` in the single cycle that follows the write.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   localparam int unsigned FLAG_W        = 32;
   localparam int unsigned BIT_PWR_ON    = 31;
   localparam int unsigned BIT_SOFT_PWR  = 30;
   localparam int unsigned BIT_SOFT_EXT  = 29;
   localparam int unsigned BIT_BTN_PWR   = 28;
   localparam int unsigned BIT_BTN_EXT   = 27;

   localparam logic [FLAG_W-1:0] KEEP_MASK  = 32'hF800_0000;
   localparam logic [FLAG_W-1:0] CLR1_MASK  = 32'h9800_0000;
   localparam logic [FLAG_W-1:0] SET1_MASK  = 32'h6000_0000;
   localparam logic [FLAG_W-1:0] PWR_ON_VAL = 32'h8000_0000;

   typedef enum logic [1:0] {
      BIT_UNUSED = 2'd0,
      BIT_W1C    = 2'd1,
      BIT_W1S    = 2'd2
   } bit_kind_e;

   function automatic bit_kind_e kind_of(input int unsigned idx);
      if (idx < FLAG_W && CLR1_MASK[idx]) return BIT_W1C;
      if (idx < FLAG_W && SET1_MASK[idx]) return BIT_W1S;
      return BIT_UNUSED;
   endfunction
endpackage

// File: rtl/rcc_decode.sv
module rcc_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int unsigned WORD_LSB = 3;

   if (ADDR_W <= WORD_LSB) begin : g_bad_width
      $error("rcc_decode: ADDR_W too small");
   end
   if (BASE_ADDR[WORD_LSB-1:0] != '0) begin : g_bad_base
      $error("rcc_decode: BASE_ADDR must be 8-byte aligned");
   end

   always_comb begin
      hit = (addr[ADDR_W-1:WORD_LSB] == BASE_ADDR[ADDR_W-1:WORD_LSB]) && addr[2];
   end
endmodule

// File: rtl/rcc_store.sv
module rcc_store
   import rcc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rst_done,
   output logic [DATA_W-1:0] cause_q,
   output logic              arm_q
);
   if (DATA_W < FLAG_W) begin : g_bad_width
      $error("rcc_store: DATA_W must be at least 32");
   end

   localparam logic [DATA_W-1:0] LOAD_VAL = DATA_W'(PWR_ON_VAL);
   localparam logic [DATA_W-1:0] KEEP     = DATA_W'(KEEP_MASK);

   logic [DATA_W-1:0] wv;
   logic [DATA_W-1:0] upd;
   logic              take_wr;

   assign wv      = wr_data & KEEP;
   assign take_wr = wr_hit && !rst_done;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (kind_of(i) == BIT_W1C) begin : g_w1c
         assign upd[i] = cause_q[i] & ~wv[i];
      end else if (kind_of(i) == BIT_W1S) begin : g_w1s
         assign upd[i] = cause_q[i] | wv[i];
      end else begin : g_zero
         assign upd[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= LOAD_VAL;
         arm_q   <= 1'b0;
      end else if (rst_done) begin
         if (arm_q) cause_q <= LOAD_VAL;
         arm_q <= 1'b0;
      end else if (take_wr) begin
         cause_q <= upd;
         if (wv[BIT_SOFT_PWR]) arm_q <= 1'b1;
      end
   end

   assert_arm_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_done && arm_q) |=> (cause_q == LOAD_VAL));
   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_done && !arm_q) |=> $stable(cause_q));
   assert_arm_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !rst_done && wr_data[BIT_SOFT_PWR]) |=> arm_q);
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !rst_done) |=> $stable(cause_q));
   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !rst_done && wr_data[BIT_PWR_ON]) |=> !cause_q[BIT_PWR_ON]);
   assert_w1s_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !rst_done && wr_data[BIT_SOFT_EXT]) |=> cause_q[BIT_SOFT_EXT]);
   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_done && !arm_q && wr_hit) |=> !arm_q);
endmodule

// File: rtl/rcc_req.sv
module rcc_req
   import rcc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rst_done,
   output logic              req_q
);
   logic ask;

   assign ask = wr_hit && !rst_done &&
                (wr_data[BIT_SOFT_PWR] || wr_data[BIT_SOFT_EXT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= ask;
   end

   assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(wr_hit && !rst_done));
   assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !wr_hit) |=> !req_q);
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wr_data,
   output logic [DATA_W-1:0] reg_rd_data,
   input  logic              sys_reset_done,
   output logic              sys_reset_req
);
   logic              hit;
   logic              wr_hit;
   logic [DATA_W-1:0] cause_q;
   logic              arm_q;

   rcc_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
      .addr (reg_addr),
      .hit  (hit)
   );

   assign wr_hit = reg_wr_en && hit;

   rcc_store #(.DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit),
      .wr_data  (reg_wr_data),
      .rst_done (sys_reset_done),
      .cause_q  (cause_q),
      .arm_q    (arm_q)
   );

   rcc_req #(.DATA_W(DATA_W)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit),
      .wr_data  (reg_wr_data),
      .rst_done (sys_reset_done),
      .req_q    (sys_reset_req)
   );

   assign reg_rd_data = hit ? cause_q : '0;

   assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_data[26:0] == '0);
   assert_miss_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !hit && !sys_reset_done) |=> !sys_reset_req);
endmodule

// File: tb/rst_cause_ctrl_bench.sv
module rst_cause_ctrl_bench;
   localparam int unsigned AW = 16;
   localparam int unsigned DW = 32;
   localparam logic [AW-1:0] BASE = 16'hF020;
   localparam logic [AW-1:0] LIVE = BASE + 16'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = LIVE;
   logic          reg_wr_en = 1'b0;
   logic [DW-1:0] reg_wr_data = '0;
   logic [DW-1:0] reg_rd_data;
   logic          sys_reset_done = 1'b0;
   logic          sys_reset_req;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] m_cause;
   logic        m_arm;
   logic        m_req;

   always #4 clk = ~clk;

   rst_cause_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(BASE)) u_rst_cause_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
      .sys_reset_done(sys_reset_done), .sys_reset_req(sys_reset_req)
   );

   function automatic logic is_live(input logic [AW-1:0] a);
      return (a[AW-1:3] == BASE[AW-1:3]) && a[2];
   endfunction

   function automatic logic [31:0] apply_wr(input logic [31:0] c, input logic [31:0] d);
      logic [31:0] v;
      v = d & 32'hF800_0000;
      return (c & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock cycle of stimulus, model update, then port check at the live word
   task automatic step(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic dn, input string tag);
      @(negedge clk);
      reg_wr_en = we; reg_addr = a; reg_wr_data = d; sys_reset_done = dn;
      @(posedge clk);
      m_req = 1'b0;
      if (dn) begin
         if (m_arm) m_cause = 32'h8000_0000;
         m_arm = 1'b0;
      end else if (we && is_live(a)) begin
         m_cause = apply_wr(m_cause, d);
         if (d[30]) m_arm = 1'b1;
         m_req = d[30] | d[29];
      end
      @(negedge clk);
      reg_wr_en = 1'b0; sys_reset_done = 1'b0; reg_addr = LIVE;
      #1;
      check({tag, " value"}, reg_rd_data, m_cause);
      check({tag, " req"}, {31'd0, sys_reset_req}, {31'd0, m_req});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [AW-1:0] a;
      logic [31:0]   d;
      m_cause = 32'h8000_0000; m_arm = 1'b0; m_req = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R1 reset value", reg_rd_data, 32'h8000_0000);
      check("R1 reset req", {31'd0, sys_reset_req}, 32'd0);

      // R2: inactive word and other address
      step(1'b1, BASE, 32'hFFFF_FFFF, 1'b0, "R2 low word write");
      step(1'b1, BASE + 16'd8, 32'hFFFF_FFFF, 1'b0, "R2 next word write");
      @(negedge clk); reg_addr = BASE + 16'd1; #1;
      check("R2 low word read", reg_rd_data, 32'd0);
      reg_addr = BASE + 16'd7; #1;
      check("R2 byte 7 read", reg_rd_data, m_cause);
      reg_addr = LIVE;
      // R10: idle reads
      step(1'b0, LIVE, 32'hFFFF_FFFF, 1'b0, "R10 idle read");
      step(1'b0, LIVE, 32'hFFFF_FFFF, 1'b0, "R10 idle read again");
      // R5
      step(1'b1, LIVE, 32'h07FF_FFFF, 1'b0, "R5 low bits");
      // R3
      step(1'b1, LIVE, 32'h8000_0000, 1'b0, "R3 clear power-on");
      // R4 and R7
      step(1'b1, LIVE, 32'h2000_0000, 1'b0, "R7 soft ext request");
      step(1'b0, LIVE, 32'h0, 1'b0, "R7 pulse ends");
      step(1'b1, LIVE, 32'h0, 1'b0, "R4 zero keeps");
      step(1'b0, LIVE, 32'h0, 1'b1, "R7 reset keeps");
      // R9
      step(1'b1, LIVE, 32'h4000_0000, 1'b1, "R9 write during reset");
      step(1'b0, LIVE, 32'h0, 1'b1, "R9 no arm left");
      // R6 and R8
      step(1'b1, LIVE, 32'h4000_0000, 1'b0, "R6 soft power request");
      step(1'b0, LIVE, 32'h0, 1'b0, "R6 pulse ends");
      step(1'b0, LIVE, 32'h0, 1'b1, "R6 reset loads");
      step(1'b0, LIVE, 32'h0, 1'b1, "R8 arm consumed");
      step(1'b1, LIVE, 32'h6000_0000, 1'b0, "R6 both requests");
      step(1'b1, LIVE, 32'h6000_0000, 1'b0, "R6 back to back");

      // random mix
      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         case ($urandom_range(0, 4))
            0:       a = BASE + 16'($urandom_range(0, 3));
            1:       a = 16'($urandom);
            default: a = BASE + 16'($urandom_range(4, 7));
         endcase
         d = $urandom;
         if ($urandom_range(0, 3) == 0) d[30] = 1'b0;
         step($urandom_range(0, 2) != 0, a, d, $urandom_range(0, 7) == 0, "R3 R4 R6 R8 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule